// File: doc/BRIEF.md
# Banked Cache Round Arbiter

This block arbitrates access from several processor cores to a shared second-level cache split into independent banks. Each core pushes its requests into a private first-in first-out queue. A global scheduler then works in rounds. At the start of a round it takes the head request of every core whose queue is not empty. Requests aimed at different banks start together in the first cycle of the round. Requests that collide on one bank are lined up behind each other.

A round closes only when every request admitted to it has finished its bank access. A waiting queue is admitted at the edge that ends the last access, so no idle cycle is spent between rounds. For every request the block reports two timing figures on completion. The first is how long the request sat in its core queue before admission. The second is how many cycles it was held back by same-bank requests from lower-numbered cores. These figures let a timing or energy analysis compare measured interference against its own bounds.

Top module: `banked_cache_arbiter`

## Requirements
- R1: The bank of a request is address bits [6:5], the two bits just above the 5-bit byte offset of a 32-byte line. The block shows that bank on `grant_bank` for the core while `grant` is high.
- R2: At no time are two requests in their bank access on the same bank. A request whose bank no lower-numbered core in the same round targets is granted in the first cycle of the round.
- R3: Requests of one core are admitted in the order the core issued them.
- R4: A round admits at most one request per core, namely the head of every non-empty queue at the admitting edge. Cores with empty queues are skipped and do not delay the others.
- R5: With requests pending, a new round is admitted at the clock edge that ends the cycle in which the last request of the previous round completes. Its first cycle directly follows. With no round running, admission happens at the first edge at which any queue is non-empty.
- R6: The reported wait of a request is the number of clock edges from the edge that accepted it into its queue to the edge that admitted it into a round. The minimum is 1.
- R7: Within a round, the conflict delay of a request is LAT (4) times the number of lower-indexed cores admitted in that round to the same bank. Its `grant` is raised in round cycle number equal to that delay, counting the first round cycle as 0.
- R8: `done` for a core is high in the LAT-th cycle of that core's bank access, which is LAT-1 cycles after its `grant`. In that cycle `done_wait` and `done_conflict` carry the R6 and R7 values.
- R9: `req_ready` of a core is low exactly when its queue holds DEPTH (4) requests. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge.
- R10: While `rst` is high and after it, until requests arrive, `grant` and `done` are all low and `req_ready` is all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORES | Per-core request strobe |
| req_addr | input | NCORES*ADDR_W | Per-core request address, core i in slice i |
| req_ready | output | NCORES | Per-core queue has room |
| grant | output | NCORES | Per-core pulse at the start of its bank access |
| grant_bank | output | NCORES*BANK_W | Bank being accessed, valid with grant |
| done | output | NCORES | Per-core pulse in the last cycle of its bank access |
| done_wait | output | NCORES*CNT_W | Queue wait of the completing request |
| done_conflict | output | NCORES*CNT_W | Bank conflict delay of the completing request |

## Verification
Acceptance is seen one edge after the strobe, through `req_ready`. Admission can come at the earliest on the edge after that, so a round's grants appear at the earliest two cycles after the request is presented. A grant is further offset by its conflict delay, and `done` follows LAT-1 cycles after the grant. The bench holds a cycle-stepped behavioural model of the queues and rounds. It advances that model by exactly one edge for every clock, with the same inputs it applies to the block. It then compares ready, grant, bank, done, wait and conflict at every falling edge, so each result is checked in exactly the cycle it is due and in no other.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;

    localparam int BA_CORES      = 6;
    localparam int BA_BANKS      = 4;
    localparam int BA_LINE_BYTES = 32;
    localparam int BA_LAT        = 4;
    localparam int BA_QDEPTH     = 4;
    localparam int BA_ADDR_W     = 16;
    localparam int BA_CNT_W      = 8;

    localparam int BA_BANK_W = $clog2(BA_BANKS);
    localparam int BA_OFF_W  = $clog2(BA_LINE_BYTES);

    typedef logic [BA_BANK_W-1:0] bank_t;
    typedef logic [BA_CNT_W-1:0]  cnt_t;

    // queued request: target bank and cycle stamp at acceptance
    typedef struct packed {
        bank_t bank;
        cnt_t  stamp;
    } qent_t;

    // one admitted request inside a round
    typedef struct packed {
        logic  act;
        bank_t bank;
        cnt_t  delay;
        cnt_t  wait_c;
    } slot_t;

    typedef enum logic {RS_IDLE, RS_BUSY} rstate_t;

    function automatic cnt_t conflict_delay(input int unsigned ahead, input int unsigned lat);
        return cnt_t'(ahead * lat);
    endfunction

endpackage

// File: rtl/bank_req_fifo.sv
module bank_req_fifo
    import bank_arb_pkg::*;
#(
    parameter int DEPTH = BA_QDEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  qent_t wdata,
    input  logic  pop,
    output qent_t head,
    output logic  empty,
    output logic  full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    qent_t             mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [OCC_W-1:0]  occ;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            if (push) wp <= step_ptr(wp);
            if (pop)  rp <= step_ptr(rp);
            occ <= occ + OCC_W'(push) - OCC_W'(pop);
        end
    end

    assign head  = mem[rp];
    assign empty = (occ == '0);
    assign full  = (occ == OCC_W'(DEPTH));

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) occ <= OCC_W'(DEPTH)); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);       // R3

endmodule

// File: rtl/bank_round_sched.sv
module bank_round_sched
    import bank_arb_pkg::*;
#(
    parameter int NCORES = BA_CORES,
    parameter int NBANKS = BA_BANKS,
    parameter int LAT    = BA_LAT
) (
    input  logic              clk,
    input  logic              rst,
    input  qent_t             head      [NCORES],
    input  logic [NCORES-1:0] nonempty,
    input  cnt_t              cyc,
    output logic [NCORES-1:0] pop,
    output logic [NCORES-1:0] grant,
    output bank_t             grant_bank [NCORES],
    output logic [NCORES-1:0] done,
    output cnt_t              done_wait [NCORES],
    output cnt_t              done_conf [NCORES]
);
    localparam cnt_t TAIL = cnt_t'(LAT - 1);

    rstate_t state;
    cnt_t    rc, last, last_nxt;
    slot_t   slot     [NCORES];
    slot_t   slot_nxt [NCORES];
    logic    load;

    // next-round contents from the current queue heads
    always_comb begin
        for (int i = 0; i < NCORES; i++) begin
            int unsigned ahead;
            ahead = 0;
            for (int j = 0; j < i; j++) begin
                if (nonempty[j] && head[j].bank == head[i].bank) ahead++;
            end
            slot_nxt[i].act    = nonempty[i];
            slot_nxt[i].bank   = head[i].bank;
            slot_nxt[i].delay  = conflict_delay(ahead, LAT);
            slot_nxt[i].wait_c = cyc - head[i].stamp;
        end
    end

    always_comb begin
        last_nxt = '0;
        for (int i = 0; i < NCORES; i++) begin
            if (slot_nxt[i].act && slot_nxt[i].delay > last_nxt) last_nxt = slot_nxt[i].delay;
        end
        last_nxt = last_nxt + TAIL;
    end

    assign load = ((state == RS_IDLE) || (rc == last)) && (|nonempty);
    assign pop  = load ? nonempty : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_IDLE;
            rc    <= '0;
            last  <= '0;
            for (int i = 0; i < NCORES; i++) slot[i] <= '0;
        end else if (load) begin
            state <= RS_BUSY;
            rc    <= '0;
            last  <= last_nxt;
            for (int i = 0; i < NCORES; i++) slot[i] <= slot_nxt[i];
        end else if (state == RS_BUSY) begin
            if (rc == last) state <= RS_IDLE;
            else            rc    <= rc + 1'b1;
        end
    end

    logic [NCORES-1:0] finished;

    for (genvar i = 0; i < NCORES; i++) begin : g_out
        logic live;
        assign live          = (state == RS_BUSY) && slot[i].act;
        assign grant[i]      = live && (rc == slot[i].delay);
        assign done[i]       = live && (rc == slot[i].delay + TAIL);
        assign grant_bank[i] = slot[i].bank;
        assign done_wait[i]  = slot[i].wait_c;
        assign done_conf[i]  = slot[i].delay;
        assign finished[i]   = !live || (rc >= slot[i].delay + TAIL);

        AST_CONFLICT_BOUND: assert property (@(posedge clk) disable iff (rst)
            done[i] |-> (done_conf[i] <= cnt_t'((NCORES - 1) * LAT)));   // R7
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [NCORES-1:0] serving;
        for (genvar i = 0; i < NCORES; i++) begin : g_core
            assign serving[i] = (state == RS_BUSY) && slot[i].act
                             && (slot[i].bank == bank_t'(b))
                             && (rc >= slot[i].delay) && (rc <= slot[i].delay + TAIL);
        end
        AST_BANK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
            $onehot0(serving));                                            // R2
    end

    AST_ROUND_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (load && state == RS_BUSY) |-> (&finished));                       // R5

endmodule

// File: rtl/banked_cache_arbiter.sv
module banked_cache_arbiter
    import bank_arb_pkg::*;
#(
    parameter int NCORES = BA_CORES,
    parameter int NBANKS = BA_BANKS,
    parameter int LAT    = BA_LAT,
    parameter int DEPTH  = BA_QDEPTH,
    parameter int ADDR_W = BA_ADDR_W,
    localparam int BANK_W = BA_BANK_W,
    localparam int CNT_W  = BA_CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCORES-1:0]        req_valid,
    input  logic [NCORES*ADDR_W-1:0] req_addr,
    output logic [NCORES-1:0]        req_ready,
    output logic [NCORES-1:0]        grant,
    output logic [NCORES*BANK_W-1:0] grant_bank,
    output logic [NCORES-1:0]        done,
    output logic [NCORES*CNT_W-1:0]  done_wait,
    output logic [NCORES*CNT_W-1:0]  done_conflict
);
    cnt_t              cyc;
    qent_t             head [NCORES];
    logic [NCORES-1:0] empty, full, pop;
    bank_t             gbank [NCORES];
    cnt_t              dwait [NCORES];
    cnt_t              dconf [NCORES];
    logic              addr_unused;

    assign addr_unused = ^req_addr;

    always_ff @(posedge clk) begin
        if (rst) cyc <= '0;
        else     cyc <= cyc + 1'b1;
    end

    for (genvar i = 0; i < NCORES; i++) begin : g_core
        qent_t in_ent;
        assign in_ent.bank  = req_addr[i*ADDR_W + BA_OFF_W +: BANK_W];
        assign in_ent.stamp = cyc;

        bank_req_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (req_valid[i] && !full[i]),
            .wdata (in_ent),
            .pop   (pop[i]),
            .head  (head[i]),
            .empty (empty[i]),
            .full  (full[i])
        );

        assign req_ready[i]                     = !full[i];
        assign grant_bank[i*BANK_W +: BANK_W]   = gbank[i];
        assign done_wait[i*CNT_W +: CNT_W]      = dwait[i];
        assign done_conflict[i*CNT_W +: CNT_W]  = dconf[i];
    end

    bank_round_sched #(.NCORES(NCORES), .NBANKS(NBANKS), .LAT(LAT)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .head       (head),
        .nonempty   (~empty),
        .cyc        (cyc),
        .pop        (pop),
        .grant      (grant),
        .grant_bank (gbank),
        .done       (done),
        .done_wait  (dwait),
        .done_conf  (dconf)
    );

endmodule

// File: tb/banked_cache_arbiter_bench.sv
`timescale 1ns/1ps
module banked_cache_arbiter_bench;
    localparam int NC  = 6;
    localparam int LAT = 4;
    localparam int DEP = 4;
    localparam int AW  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NC-1:0]   req_valid = '0;
    logic [NC*AW-1:0] req_addr = '0;
    logic [NC-1:0]   req_ready, grant, done;
    logic [NC*2-1:0] grant_bank;
    logic [NC*8-1:0] done_wait, done_conflict;

    always #4 clk = ~clk;

    banked_cache_arbiter u_banked_cache_arbiter (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .grant(grant), .grant_bank(grant_bank),
        .done(done), .done_wait(done_wait), .done_conflict(done_conflict)
    );

    int tests = 0, fails = 0;
    bit finished = 0;

    // behavioural reference state
    int mq_b [NC][$];
    int mq_s [NC][$];
    int m_cyc = 0, m_rc = 0, m_last = 0;
    bit m_act = 0;
    bit s_act [NC];
    int s_bank [NC], s_d [NC], s_w [NC];

    bit drv_v [NC];
    int drv_b [NC];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        for (int c = 0; c < NC; c++) begin
            bit eg, ed, er;
            er = mq_b[c].size() < DEP;
            eg = m_act && s_act[c] && (m_rc == s_d[c]);
            ed = m_act && s_act[c] && (m_rc == s_d[c] + LAT - 1);
            chk(req_ready[c] == er, "R9", $sformatf("ready core %0d", c), req_ready[c], er);
            chk(grant[c] == eg, "R7", $sformatf("grant core %0d", c), grant[c], eg);
            chk(done[c] == ed, "R8", $sformatf("done core %0d", c), done[c], ed);
            if (eg && grant[c])
                chk(grant_bank[c*2 +: 2] == s_bank[c], "R1", $sformatf("bank core %0d", c),
                    grant_bank[c*2 +: 2], s_bank[c]);
            if (ed && done[c]) begin
                chk(done_wait[c*8 +: 8] == s_w[c], "R6", $sformatf("wait core %0d", c),
                    done_wait[c*8 +: 8], s_w[c]);
                chk(done_conflict[c*8 +: 8] == s_d[c], "R7", $sformatf("conflict core %0d", c),
                    done_conflict[c*8 +: 8], s_d[c]);
            end
        end
    endtask

    task automatic model_step();
        bit rdy [NC];
        bit anyne = 0;
        bit ld;
        for (int c = 0; c < NC; c++) begin
            rdy[c] = mq_b[c].size() < DEP;
            if (mq_b[c].size() > 0) anyne = 1;
        end
        ld = (!m_act || m_rc == m_last) && anyne;
        if (ld) begin
            int mx = 0;
            for (int c = 0; c < NC; c++) begin
                s_act[c] = mq_b[c].size() > 0;
                if (s_act[c]) begin
                    s_bank[c] = mq_b[c].pop_front();
                    s_w[c]    = (m_cyc - mq_s[c].pop_front()) & 255;
                end
            end
            for (int c = 0; c < NC; c++) begin
                int n = 0;
                for (int j = 0; j < c; j++) if (s_act[j] && s_bank[j] == s_bank[c]) n++;
                s_d[c] = n * LAT;
                if (s_act[c] && s_d[c] > mx) mx = s_d[c];
            end
            m_last = mx + LAT - 1;
            m_rc = 0;
            m_act = 1;
        end else if (m_act) begin
            if (m_rc == m_last) m_act = 0;
            else m_rc++;
        end
        for (int c = 0; c < NC; c++) begin
            if (drv_v[c] && rdy[c]) begin
                mq_b[c].push_back(drv_b[c]);
                mq_s[c].push_back(m_cyc & 255);
            end
        end
        m_cyc++;
    endtask

    // one clock: check outputs, apply inputs, advance model, wait for next falling edge
    task automatic cycle();
        compare();
        for (int c = 0; c < NC; c++) begin
            logic [15:0] a;
            a = 16'($urandom) & 16'hFF80;
            a = a | 16'(drv_b[c] << 5) | (16'($urandom) & 16'h001F);
            req_valid[c] = drv_v[c];
            req_addr[c*AW +: AW] = a;
        end
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < NC; c++) drv_v[c] = 0;
        for (int k = 0; k < n; k++) cycle();
    endtask

    initial begin
        for (int c = 0; c < NC; c++) begin drv_v[c] = 0; drv_b[c] = 0; s_act[c] = 0; end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(req_ready == '1, "R10", "ready in reset", int'(req_ready), 63);
        chk(grant == '0, "R10", "grant in reset", int'(grant), 0);
        chk(done == '0, "R10", "done in reset", int'(done), 0);
        rst = 1'b0;
        idle(2);

        // R2 R7: all cores to bank 2, full serialisation
        for (int c = 0; c < NC; c++) begin drv_v[c] = 1; drv_b[c] = 2; end
        cycle();
        idle(35);

        // R2: spread banks, pairs collide
        for (int c = 0; c < NC; c++) begin drv_v[c] = 1; drv_b[c] = c % 4; end
        cycle();
        idle(20);

        // R3 R9: burst on core 0 fills its queue
        for (int k = 0; k < 10; k++) begin
            for (int c = 0; c < NC; c++) drv_v[c] = 0;
            drv_v[0] = 1; drv_b[0] = k % 4;
            cycle();
        end
        idle(60);

        // R4: only cores 2 and 5 active, empty cores skipped
        for (int k = 0; k < 6; k++) begin
            for (int c = 0; c < NC; c++) drv_v[c] = 0;
            drv_v[2] = 1; drv_b[2] = 1;
            drv_v[5] = (k % 2 == 0); drv_b[5] = 1;
            cycle();
        end
        idle(60);

        // R5 R6: random traffic, back-to-back rounds
        for (int k = 0; k < 3000; k++) begin
            for (int c = 0; c < NC; c++) begin
                drv_v[c] = ($urandom % 10) < 3;
                drv_b[c] = $urandom % 4;
            end
            cycle();
        end
        idle(120);

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: run hung actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule